// File: doc/BRIEF.md
# Serial Character Transmitter with Clear-to-Send Gating

This block turns characters into asynchronous serial frames on a single output line. Software places one character into a one-deep holding buffer through a write strobe. When the transmitter is enabled and the buffer holds a character, the character moves into an internal shift register and goes out as one frame. If clear-to-send gating is selected, the frame also waits for the active-low clear-to-send input. Every frame is a low start bit, then the data bits least significant first, then an optional parity bit, then one or two high stop bits. The line rests high between frames.

Timing comes from a bit-rate tick supplied from outside. Each bit lasts a fixed number of ticks, sixteen by default. The frame format is read from configuration inputs at the moment a character is loaded, so a format change never disturbs a frame already in flight. The holding buffer is freed as soon as its character is loaded. The next character can therefore be queued during the current frame and follows it with no idle gap. A one-cycle interrupt pulse can mark either the load of a character or the end of its last stop bit.

Top module: `uart_tx_cts`

## Requirements
- R1: `char_len` selects the data length: 2'b00 gives 7 bits, 2'b10 gives 9 bits, and 2'b01 or 2'b11 give 8 bits. The data bits are taken from the low bits of the buffered character and follow the low start bit, least significant first.
- R2: When `par_en` is 1, a parity bit follows the data bits. With `par_odd` = 0 it makes the count of ones in data plus parity even, and with `par_odd` = 1 it makes that count odd. When `par_en` is 0, no parity bit is sent.
- R3: After the data bits and any parity bit, the frame carries one high stop bit, or two when `two_stop` = 1. `txd` is high whenever no frame is being sent.
- R4: A frame starts only when `tx_en` = 1 and the buffer holds a character. Clearing `tx_en` during a frame does not shorten that frame.
- R5: When `cts_sel` = 1, a frame starts only while `cts_n` = 0. `cts_n` is looked at only where a frame would start, so raising it mid-frame does not cut the frame short. When `cts_sel` = 0, `cts_n` has no effect.
- R6: With `irq_sel` = 0, `irq` is high for one cycle, in the cycle in which the start bit first appears on `txd`.
- R7: With `irq_sel` = 1, `irq` is high for one cycle, in the cycle right after the last stop bit ends. No pulse is given when the character is loaded.
- R8: `buf_empty` goes to 1 in the same cycle that the start bit appears. A write sets it to 0. A write while the buffer is full replaces the held character.
- R9: Every bit lasts exactly `OVS` (16) ticks. The start bit appears one clock after the load. The n-th tick counted after the load edge ends bit n/`OVS` - 1.
- R10: A character queued during a frame is loaded on the edge at which that frame's last stop bit ends. Its start bit directly follows the stop bit, with no high gap.
- R11: After reset, `txd` = 1, `buf_empty` = 1 and `irq` = 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| tick | input | 1 | Bit-rate tick, one clock wide, OVS per bit |
| tx_en | input | 1 | Transmitter enable |
| cts_sel | input | 1 | 1 = start of a frame is gated by cts_n |
| cts_n | input | 1 | Clear-to-send, active low |
| char_len | input | 2 | Data length select (7/8/9 bits) |
| par_en | input | 1 | Parity bit enable |
| par_odd | input | 1 | 1 = odd parity, 0 = even parity |
| two_stop | input | 1 | 1 = two stop bits |
| irq_sel | input | 1 | Interrupt point: 0 = load, 1 = end of frame |
| wr_stb | input | 1 | Buffer write strobe |
| wr_data | input | 9 | Character to buffer |
| buf_empty | output | 1 | Buffer holds no character |
| txd | output | 1 | Serial output line |
| irq | output | 1 | Interrupt pulse, one clock wide |

## Verification
The bench keeps the default `OVS` of 16 and drives `tick` once every three clocks, so one bit spans 48 clocks. A frame of up to 13 bits then takes only a few hundred cycles. This lets the bench send every combination of data length, parity mode, stop count and interrupt point, each with several character values. Each bit is checked at its midpoint, and the start-bit boundary is checked on the exact tick. The same short bit time leaves room for directed runs on enable and clear-to-send gating, on overwriting the buffer, and on sending two frames back to back.

// File: rtl/uart_tx_cts.sv
module uart_tx_cts #(
  parameter int OVS = 16
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick,
  input  logic       tx_en,
  input  logic       cts_sel,
  input  logic       cts_n,
  input  logic [1:0] char_len,
  input  logic       par_en,
  input  logic       par_odd,
  input  logic       two_stop,
  input  logic       irq_sel,
  input  logic       wr_stb,
  input  logic [8:0] wr_data,
  output logic       buf_empty,
  output logic       txd,
  output logic       irq
);

  localparam int TCW = (OVS > 1) ? $clog2(OVS) : 1;
  localparam int FW  = 13;
  localparam int BCW = $clog2(FW + 1);

  logic [8:0]     buf_q;
  logic           buf_full;
  logic           busy;
  logic [TCW-1:0] tcnt;
  logic [BCW-1:0] left;
  logic [FW-2:0]  sh;
  logic           txd_q, irq_q;

  logic [FW-1:0]  frame;
  logic [BCW-1:0] flen;
  logic [8:0]     dmask;
  int             dlen;

  wire bit_end   = busy && tick && (tcnt == TCW'(OVS - 1));
  wire frame_end = bit_end && (left == BCW'(1));
  wire cts_ok    = !cts_sel || !cts_n;
  wire load      = (!busy || frame_end) && buf_full && tx_en && cts_ok;

  always_comb begin
    case (char_len)
      2'b00:   dlen = 7;
      2'b10:   dlen = 9;
      default: dlen = 8;
    endcase
    dmask = buf_q;
    if (dlen < 9) dmask[8] = 1'b0;
    if (dlen < 8) dmask[7] = 1'b0;
    frame    = '1;
    frame[0] = 1'b0;
    for (int i = 0; i < 9; i++)
      if (i < dlen) frame[1+i] = buf_q[i];
    if (par_en) frame[1+dlen] = (^dmask) ^ par_odd;
    flen = BCW'(1 + dlen + (par_en ? 1 : 0) + (two_stop ? 2 : 1));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy  <= 1'b0;
      tcnt  <= '0;
      left  <= '0;
      sh    <= '1;
      txd_q <= 1'b1;
      irq_q <= 1'b0;
    end else begin
      irq_q <= irq_sel ? frame_end : load;
      if (load) begin
        busy  <= 1'b1;
        tcnt  <= '0;
        left  <= flen;
        txd_q <= frame[0];
        sh    <= frame[FW-1:1];
      end else if (frame_end) begin
        busy  <= 1'b0;
        tcnt  <= '0;
        left  <= '0;
        txd_q <= 1'b1;
      end else if (bit_end) begin
        tcnt  <= '0;
        left  <= left - BCW'(1);
        txd_q <= sh[0];
        sh    <= {1'b1, sh[FW-2:1]};
      end else if (busy && tick) begin
        tcnt  <= tcnt + TCW'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      buf_q    <= '0;
      buf_full <= 1'b0;
    end else if (wr_stb) begin
      buf_q    <= wr_data;
      buf_full <= 1'b1;
    end else if (load) begin
      buf_full <= 1'b0;
    end
  end

  assign buf_empty = !buf_full;
  assign txd       = txd_q;
  assign irq       = irq_q;

  assert_idle_high_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> txd_q);

  assert_start_low_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> !txd_q);

  assert_start_gate_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(tx_en && buf_full));

  assert_cts_gate_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(busy) && $past(cts_sel)) |-> !$past(cts_n));

  assert_empty_after_load_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> (buf_empty || $past(wr_stb)));

  assert_tick_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !tick) |=> $stable(tcnt));

endmodule

// File: tb/tb_uart_tx_cts.sv
module tb_uart_tx_cts;
  logic clk = 0, rst_n = 0, tick = 0;
  logic tx_en = 0, cts_sel = 0, cts_n = 1;
  logic [1:0] char_len = 2'b01;
  logic par_en = 0, par_odd = 0, two_stop = 0, irq_sel = 0;
  logic wr_stb = 0;
  logic [8:0] wr_data = '0;
  logic buf_empty, txd, irq;

  int n_cmp = 0, n_bad = 0;
  bit done = 0;

  uart_tx_cts dut (.*);

  always #2 clk = ~clk;

  initial begin
    int c = 0;
    forever begin
      @(negedge clk);
      tick = (c == 0);
      c = (c == 2) ? 0 : c + 1;
    end
  end

  task automatic chk(bit ok, string req, int act, int exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int dl(int cl);
    return (cl == 0) ? 7 : (cl == 2) ? 9 : 8;
  endfunction

  function automatic int nbits(int cl, int pm, int st);
    return 1 + dl(cl) + (pm != 0 ? 1 : 0) + (st != 0 ? 2 : 1);
  endfunction

  // pm: 0 none, 1 even, 2 odd
  function automatic int exp_bit(int k, int d, int cl, int pm);
    int L = dl(cl);
    int ones = 0;
    if (k == 0) return 0;
    if (k <= L) return (d >> (k - 1)) & 1;
    if (k == L + 1 && pm != 0) begin
      for (int i = 0; i < L; i++) ones += (d >> i) & 1;
      return (pm == 2) ? ((ones % 2) == 0 ? 1 : 0) : (ones % 2);
    end
    return 1;
  endfunction

  task automatic setcfg(int cl, int pm, int st, int is);
    char_len = 2'(cl);
    par_en   = (pm != 0);
    par_odd  = (pm == 2);
    two_stop = (st != 0);
    irq_sel  = (is != 0);
  endtask

  task automatic wr(int d);
    @(negedge clk);
    wr_stb = 1; wr_data = 9'(d);
    @(negedge clk);
    wr_stb = 0;
  endtask

  task automatic frame_check(int d, int cl, int pm, int st, int is, bit next, bit chk_empty);
    int guard = 0, cnt = 0, k = 0, n;
    bit t;
    n = nbits(cl, pm, st);
    while (txd !== 1'b0 && guard < 5000) begin @(negedge clk); guard++; end
    chk(guard < 5000, "R4 frame start", int'(txd), 0);
    chk(irq == (is == 0), "R6/R7 irq at load", int'(irq), int'(is == 0));
    if (chk_empty) chk(buf_empty == 1'b1, "R8 empty at load", int'(buf_empty), 1);
    while (cnt < 16 * n) begin
      @(posedge clk); t = tick;
      @(negedge clk);
      if (t) begin
        cnt++;
        if (cnt == 15) chk(txd == 1'b0, "R9 start bit length", int'(txd), 0);
        if (cnt == 16) chk(int'(txd) == exp_bit(1, d, cl, pm), "R9 bit boundary", int'(txd), exp_bit(1, d, cl, pm));
        if (cnt == 16 * k + 8) begin
          chk(int'(txd) == exp_bit(k, d, cl, pm), "R1/R2/R3 frame bit", int'(txd), exp_bit(k, d, cl, pm));
          k++;
        end
      end
    end
    chk(irq == (is == 1 || next), "R7 irq at frame end", int'(irq), int'(is == 1 || next));
    chk(txd == !next, "R10/R3 line after frame", int'(txd), int'(!next));
  endtask

  task automatic idle_window(int n, string req);
    bit stayed = 1;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (txd !== 1'b1) stayed = 0;
    end
    chk(stayed, req, int'(stayed), 1);
  endtask

  initial begin
    repeat (400000) @(posedge clk);
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(txd == 1'b1, "R11 reset txd", int'(txd), 1);
    chk(buf_empty == 1'b1, "R11 reset buf_empty", int'(buf_empty), 1);
    chk(irq == 1'b0, "R11 reset irq", int'(irq), 0);
    rst_n = 1;
    tx_en = 1;
    repeat (2) @(negedge clk);

    // R1 R2 R3 R6 R7 R8 R9 sweep
    for (int cl = 0; cl < 3; cl++)
      for (int pm = 0; pm < 3; pm++)
        for (int st = 0; st < 2; st++)
          for (int is = 0; is < 2; is++)
            for (int v = 0; v < 3; v++) begin
              int d = (9'h0A5 ^ (v * 9'h13B) ^ (cl * 9'h041) ^ (pm * 9'h106)) & 9'h1FF;
              setcfg(cl, pm, st, is);
              wr(d);
              frame_check(d, cl, pm, st, is, 0, 1);
              repeat (3) @(negedge clk);
            end

    setcfg(1, 0, 0, 0);

    // R4: disabled transmitter holds the character
    tx_en = 0;
    wr(9'h0C3);
    idle_window(300, "R4 no start while disabled");
    chk(buf_empty == 1'b0, "R4 buffer kept while disabled", int'(buf_empty), 0);
    tx_en = 1;
    fork
      frame_check(9'h0C3, 1, 0, 0, 0, 0, 1);
      begin repeat (100) @(negedge clk); tx_en = 0; end
    join
    tx_en = 1;
    repeat (3) @(negedge clk);

    // R5: clear-to-send gating
    cts_sel = 1; cts_n = 1;
    wr(9'h05A);
    idle_window(300, "R5 no start while cts high");
    chk(buf_empty == 1'b0, "R5 buffer kept while cts high", int'(buf_empty), 0);
    cts_n = 0;
    fork
      frame_check(9'h05A, 1, 0, 0, 0, 0, 1);
      begin repeat (100) @(negedge clk); cts_n = 1; end
    join
    cts_sel = 0;
    wr(9'h0F0);
    frame_check(9'h0F0, 1, 0, 0, 0, 0, 1); // R5 cts ignored when not selected
    cts_n = 0;
    repeat (3) @(negedge clk);

    // R8: overwrite while full
    tx_en = 0;
    wr(9'h011);
    wr(9'h0EE);
    tx_en = 1;
    frame_check(9'h0EE, 1, 0, 0, 0, 0, 1);
    repeat (3) @(negedge clk);

    // R10: back-to-back frames
    setcfg(2, 2, 1, 0);
    wr(9'h155);
    fork
      frame_check(9'h155, 2, 2, 1, 0, 1, 1);
      begin repeat (60) @(negedge clk); wr(9'h0AA); end
    join
    frame_check(9'h0AA, 2, 2, 1, 0, 0, 1);

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule